// File: doc/BRIEF.md
# Submission/Completion Ring Pair Controller

This block is the device-side engine for one command ring and one completion ring, both held in host memory. The host writes commands into the submission ring and then reports its new producer index through a doorbell write. The block sees that its consumer index trails that value. It reads the next 64-byte command over a memory read port, passes the whole entry to a downstream processing engine, and advances its consumer index.

When the engine reports that a command is done, the block builds a 16-byte completion entry and writes it into the completion ring at its own producer index. After the memory write is accepted, it pulses an interrupt request. The host frees completion slots by writing its consumer index to a second doorbell. Doorbell writes carry a 16-bit queue identifier, which leaves room for 65536 ring pairs. This instance answers only to the identifier set by a parameter.

Top module: `sq_cq_pair_ctrl`

## Requirements
- R1: After a synchronous reset, every ring index is zero and the phase tag is 1. `rdReqValid`, `cmdValid`, `cplValid`, `irq` and `dbErr` are low, and `doneReady` is high.
- R2: While the fetch index differs from the last accepted submission doorbell value, the block requests the entry at address `SQ_BASE + 64*index`. It never requests an entry at the doorbell value itself.
- R3: At most one fetch is in flight. No new read request is raised until the previous response has been handed to the engine. A pending request holds its address until `rdReqReady`.
- R4: Response data is passed unchanged on `cmdData`, in ring order. The fetch index advances when `cmdValid && cmdReady`, and it wraps to 0 after `QDEPTH-1`.
- R5: A done accepted on `doneValid && doneReady` produces one completion write at `CQ_BASE + 16*cqTail`. The entry holds the fetch index at done time in bits [15:0], the command identifier in bits [31:16], the phase tag in bit 32 and the status in bits [47:33]. All other bits are zero. The write is held stable until `cplReady`.
- R6: The phase tag is 1 from reset and inverts each time the completion producer index wraps from `QDEPTH-1` to 0.
- R7: `irq` is high for exactly the one cycle that follows each accepted completion write, and is low at all other times.
- R8: `doneReady` is low while a completion is waiting to be written. It is also low while advancing the completion producer index would make it equal to the host's completion consumer index.
- R9: A completion doorbell write with an in-range value sets the host consumer index, so that stalled completions can proceed.
- R10: A doorbell write for this queue whose value is `QDEPTH` or larger changes no index and sets `dbErr`. `dbErr` stays set until reset.
- R11: A doorbell write whose queue identifier differs from `OWN_QID` changes nothing and does not set `dbErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbWrEn | input | 1 | Doorbell write strobe |
| dbWrSel | input | 1 | 0 = submission producer index, 1 = completion consumer index |
| dbWrQid | input | 16 | Queue identifier of the doorbell write |
| dbWrData | input | 16 | New index value |
| dbErr | output | 1 | Sticky out-of-range doorbell flag |
| rdReqValid | output | 1 | Command read request valid |
| rdReqReady | input | 1 | Read request accepted |
| rdReqAddr | output | ADDR_W | Byte address of the command entry |
| rdRspValid | input | 1 | Read response valid |
| rdRspData | input | 512 | Command entry returned from memory |
| cmdValid | output | 1 | Command offered to the engine |
| cmdReady | input | 1 | Engine accepts the command |
| cmdData | output | 512 | Command entry |
| doneValid | input | 1 | Engine reports a finished command |
| doneReady | output | 1 | Block can take a done report |
| doneCid | input | CID_W | Identifier of the finished command |
| doneStatus | input | STAT_W | Status of the finished command |
| cplValid | output | 1 | Completion write valid |
| cplReady | input | 1 | Completion write accepted |
| cplAddr | output | ADDR_W | Byte address of the completion slot |
| cplData | output | 128 | Completion entry |
| irq | output | 1 | Interrupt request pulse |

## Verification
A fetch index that drifts shows on the very next read request as a wrong address. It also shows one engine handoff later as a wrong command-identifier sequence, and in the head field of every later completion. A wrong completion producer index or phase tag shows in the address or bit 32 of the next completion write. A faulty full test shows in the same cycle as a `doneReady` value that disagrees with the count of posted and freed slots. A missing or extra interrupt is caught in the cycle after each write handshake. Random ready back-pressure on all three downstream ports, with a small ring so that both indices wrap many times, keeps these windows short.

// File: rtl/qpair_pkg.sv
package qpair_pkg;
  localparam int SQE_BITS  = 512;  // one 64-byte command
  localparam int CQE_BITS  = 128;  // one 16-byte completion
  localparam int SQE_SHIFT = 6;
  localparam int CQE_SHIFT = 4;
  localparam int DB_W      = 16;   // doorbell value width
  localparam int QID_W     = 16;   // queue identifier width

  typedef enum logic [1:0] {
    FETCH_IDLE,
    FETCH_REQ,
    FETCH_WAIT,
    FETCH_HAND
  } fetchState_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic sqHeadStep;
    logic cmdCapture;
    logic cplCapture;
    logic cqTailStep;
  } qpStrobe_t;
endpackage

// File: rtl/qpair_dp.sv
module qpair_dp
  import qpair_pkg::*;
#(
  parameter int QDEPTH = 64,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] SQ_BASE = ADDR_W'('h1000_0000),
  parameter logic [ADDR_W-1:0] CQ_BASE = ADDR_W'('h2000_0000),
  parameter int OWN_QID = 1,
  parameter int CID_W  = 16,
  parameter int STAT_W = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  qpStrobe_t           strobe,
  input  logic                dbWrEn,
  input  logic                dbWrSel,
  input  logic [QID_W-1:0]    dbWrQid,
  input  logic [DB_W-1:0]     dbWrData,
  input  logic [SQE_BITS-1:0] rdRspData,
  input  logic [CID_W-1:0]    doneCid,
  input  logic [STAT_W-1:0]   doneStatus,
  output logic                sqPending,
  output logic                cqFull,
  output logic [ADDR_W-1:0]   rdReqAddr,
  output logic [SQE_BITS-1:0] cmdData,
  output logic [ADDR_W-1:0]   cplAddr,
  output logic [CQE_BITS-1:0] cplData,
  output logic                dbErr
);
  localparam int PTR_W     = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CID_LSB   = DB_W;
  localparam int PHASE_BIT = CID_LSB + CID_W;
  localparam int STAT_LSB  = PHASE_BIT + 1;
  localparam int USED_BITS = STAT_LSB + STAT_W;
  localparam logic [DB_W:0] DEPTH_LIM = (DB_W+1)'(QDEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(QDEPTH - 1);

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  logic [PTR_W-1:0] sqHead, sqTail, cqHead, cqTail;
  logic             phase;
  logic             errFlag;
  logic [SQE_BITS-1:0] cmdBuf;
  logic [CID_W-1:0]    cplCid;
  logic [STAT_W-1:0]   cplStat;
  logic [PTR_W-1:0]    cplHead;

  // doorbell decode, one hit line per ring
  logic       dbOwnQid, dbInRange, dbBad;
  logic [1:0] dbHit;
  assign dbOwnQid  = (dbWrQid == QID_W'(OWN_QID));
  assign dbInRange = ({1'b0, dbWrData} < DEPTH_LIM);
  assign dbBad     = dbWrEn && dbOwnQid && !dbInRange;

  for (genvar g = 0; g < 2; g++) begin : gDbDecode
    assign dbHit[g] = dbWrEn && dbOwnQid && dbInRange && (dbWrSel == 1'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sqHead  <= '0;
      sqTail  <= '0;
      cqHead  <= '0;
      cqTail  <= '0;
      phase   <= 1'b1;
      errFlag <= 1'b0;
    end else begin
      if (dbHit[0]) sqTail <= dbWrData[PTR_W-1:0];
      if (dbHit[1]) cqHead <= dbWrData[PTR_W-1:0];
      if (dbBad)    errFlag <= 1'b1;
      if (strobe.sqHeadStep) sqHead <= ptrNext(sqHead);
      if (strobe.cqTailStep) begin
        cqTail <= ptrNext(cqTail);
        if (cqTail == LAST_IDX) phase <= ~phase;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.cmdCapture) cmdBuf <= rdRspData;
    if (strobe.cplCapture) begin
      cplCid  <= doneCid;
      cplStat <= doneStatus;
      cplHead <= sqHead;
    end
  end

  assign sqPending = (sqHead != sqTail);
  assign cqFull    = (ptrNext(cqTail) == cqHead);
  assign rdReqAddr = SQ_BASE + (ADDR_W'(sqHead) << SQE_SHIFT);
  assign cplAddr   = CQ_BASE + (ADDR_W'(cqTail) << CQE_SHIFT);
  assign cmdData   = cmdBuf;
  assign dbErr     = errFlag;

  always_comb begin
    cplData = '0;
    cplData[DB_W-1:0]               = DB_W'(cplHead);
    cplData[PHASE_BIT-1:CID_LSB]    = cplCid;
    cplData[PHASE_BIT]              = phase;
    cplData[USED_BITS-1:STAT_LSB]   = cplStat;
  end
endmodule

// File: rtl/qpair_ctrl.sv
module qpair_ctrl
  import qpair_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sqPending,
  input  logic      cqFull,
  input  logic      rdReqReady,
  input  logic      rdRspValid,
  input  logic      cmdReady,
  input  logic      doneValid,
  input  logic      cplReady,
  output logic      rdReqValid,
  output logic      cmdValid,
  output logic      doneReady,
  output logic      cplValid,
  output logic      irq,
  output qpStrobe_t strobe
);
  fetchState_e state, stateNext;
  logic        cplBusy;
  logic        irqReg;

  always_comb begin
    stateNext = state;
    unique case (state)
      FETCH_IDLE: if (sqPending)  stateNext = FETCH_REQ;
      FETCH_REQ:  if (rdReqReady) stateNext = FETCH_WAIT;
      FETCH_WAIT: if (rdRspValid) stateNext = FETCH_HAND;
      FETCH_HAND: if (cmdReady)   stateNext = FETCH_IDLE;
      default:                    stateNext = FETCH_IDLE;
    endcase
  end

  assign rdReqValid = (state == FETCH_REQ);
  assign cmdValid   = (state == FETCH_HAND);
  assign cplValid   = cplBusy;
  assign doneReady  = !cplBusy && !cqFull;

  always_comb begin
    strobe            = '0;
    strobe.sqHeadStep = cmdValid && cmdReady;
    strobe.cmdCapture = (state == FETCH_WAIT) && rdRspValid;
    strobe.cplCapture = doneValid && doneReady;
    strobe.cqTailStep = cplBusy && cplReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FETCH_IDLE;
      cplBusy <= 1'b0;
      irqReg  <= 1'b0;
    end else begin
      state  <= stateNext;
      irqReg <= strobe.cqTailStep;
      if (strobe.cplCapture)      cplBusy <= 1'b1;
      else if (strobe.cqTailStep) cplBusy <= 1'b0;
    end
  end

  assign irq = irqReg;
endmodule

// File: rtl/sq_cq_pair_ctrl.sv
module sq_cq_pair_ctrl
  import qpair_pkg::*;
#(
  parameter int QDEPTH = 64,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] SQ_BASE = ADDR_W'('h1000_0000),
  parameter logic [ADDR_W-1:0] CQ_BASE = ADDR_W'('h2000_0000),
  parameter int OWN_QID = 1,
  parameter int CID_W  = 16,
  parameter int STAT_W = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dbWrEn,
  input  logic                dbWrSel,
  input  logic [QID_W-1:0]    dbWrQid,
  input  logic [DB_W-1:0]     dbWrData,
  output logic                dbErr,
  output logic                rdReqValid,
  input  logic                rdReqReady,
  output logic [ADDR_W-1:0]   rdReqAddr,
  input  logic                rdRspValid,
  input  logic [SQE_BITS-1:0] rdRspData,
  output logic                cmdValid,
  input  logic                cmdReady,
  output logic [SQE_BITS-1:0] cmdData,
  input  logic                doneValid,
  output logic                doneReady,
  input  logic [CID_W-1:0]    doneCid,
  input  logic [STAT_W-1:0]   doneStatus,
  output logic                cplValid,
  input  logic                cplReady,
  output logic [ADDR_W-1:0]   cplAddr,
  output logic [CQE_BITS-1:0] cplData,
  output logic                irq
);
  qpStrobe_t strobe;
  logic      sqPending;
  logic      cqFull;

  qpair_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sqPending  (sqPending),
    .cqFull     (cqFull),
    .rdReqReady (rdReqReady),
    .rdRspValid (rdRspValid),
    .cmdReady   (cmdReady),
    .doneValid  (doneValid),
    .cplReady   (cplReady),
    .rdReqValid (rdReqValid),
    .cmdValid   (cmdValid),
    .doneReady  (doneReady),
    .cplValid   (cplValid),
    .irq        (irq),
    .strobe     (strobe)
  );

  qpair_dp #(
    .QDEPTH  (QDEPTH),
    .ADDR_W  (ADDR_W),
    .SQ_BASE (SQ_BASE),
    .CQ_BASE (CQ_BASE),
    .OWN_QID (OWN_QID),
    .CID_W   (CID_W),
    .STAT_W  (STAT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .dbWrEn     (dbWrEn),
    .dbWrSel    (dbWrSel),
    .dbWrQid    (dbWrQid),
    .dbWrData   (dbWrData),
    .rdRspData  (rdRspData),
    .doneCid    (doneCid),
    .doneStatus (doneStatus),
    .sqPending  (sqPending),
    .cqFull     (cqFull),
    .rdReqAddr  (rdReqAddr),
    .cmdData    (cmdData),
    .cplAddr    (cplAddr),
    .cplData    (cplData),
    .dbErr      (dbErr)
  );
endmodule

// File: rtl/qpair_checker.sv
module qpair_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rdReqValid,
  input logic              rdReqReady,
  input logic [ADDR_W-1:0] rdReqAddr,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [511:0]      cmdData,
  input logic              doneValid,
  input logic              doneReady,
  input logic              cplValid,
  input logic              cplReady,
  input logic [ADDR_W-1:0] cplAddr,
  input logic [127:0]      cplData,
  input logic              cqFull,
  input logic              dbErr,
  input logic              irq
);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    rdReqValid && !rdReqReady |=> rdReqValid && $stable(rdReqAddr));

  a_r3_single_fetch: assert property (@(posedge clk) disable iff (rst)
    rdReqValid |-> !cmdValid);

  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdData));

  a_r5_done_posts: assert property (@(posedge clk) disable iff (rst)
    doneValid && doneReady |=> cplValid);

  a_r5_cpl_hold: assert property (@(posedge clk) disable iff (rst)
    cplValid && !cplReady |=> cplValid && $stable(cplData) && $stable(cplAddr));

  a_r7_irq_after_write: assert property (@(posedge clk) disable iff (rst)
    cplValid && cplReady |=> irq);

  a_r7_irq_only_after_write: assert property (@(posedge clk) disable iff (rst)
    !(cplValid && cplReady) |=> !irq);

  a_r8_full_blocks_done: assert property (@(posedge clk) disable iff (rst)
    cqFull |-> !doneReady);

  a_r8_one_in_flight: assert property (@(posedge clk) disable iff (rst)
    cplValid |-> !doneReady);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    dbErr |=> dbErr);
endmodule

bind sq_cq_pair_ctrl qpair_checker #(.ADDR_W(ADDR_W)) chk (
  .clk        (clk),
  .rst        (rst),
  .rdReqValid (rdReqValid),
  .rdReqReady (rdReqReady),
  .rdReqAddr  (rdReqAddr),
  .cmdValid   (cmdValid),
  .cmdReady   (cmdReady),
  .cmdData    (cmdData),
  .doneValid  (doneValid),
  .doneReady  (doneReady),
  .cplValid   (cplValid),
  .cplReady   (cplReady),
  .cplAddr    (cplAddr),
  .cplData    (cplData),
  .cqFull     (cqFull),
  .dbErr      (dbErr),
  .irq        (irq)
);

// File: tb/sq_cq_pair_ctrl_test.sv
`timescale 1ns/1ps
module sq_cq_pair_ctrl_test;
  localparam int QD  = 8;
  localparam int AW  = 32;
  localparam int QID = 5;
  localparam logic [31:0] SQB = 32'h1000_0000;
  localparam logic [31:0] CQB = 32'h2000_0000;

  logic clk = 0, rst = 1;
  logic dbWrEn = 0, dbWrSel = 0;
  logic [15:0] dbWrQid = 0, dbWrData = 0;
  logic dbErr, rdReqValid, rdReqReady = 0, rdRspValid = 0;
  logic [AW-1:0] rdReqAddr, cplAddr;
  logic [511:0] rdRspData = '0, cmdData;
  logic cmdValid, cmdReady = 0, doneValid = 0, doneReady;
  logic [15:0] doneCid = 0;
  logic [14:0] doneStatus = 0;
  logic cplValid, cplReady = 0, irq;
  logic [127:0] cplData;

  sq_cq_pair_ctrl #(.QDEPTH(QD), .ADDR_W(AW), .SQ_BASE(SQB), .CQ_BASE(CQB),
                    .OWN_QID(QID), .CID_W(16), .STAT_W(15)) uut (
    .clk(clk), .rst(rst), .dbWrEn(dbWrEn), .dbWrSel(dbWrSel), .dbWrQid(dbWrQid),
    .dbWrData(dbWrData), .dbErr(dbErr), .rdReqValid(rdReqValid), .rdReqReady(rdReqReady),
    .rdReqAddr(rdReqAddr), .rdRspValid(rdRspValid), .rdRspData(rdRspData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData), .doneValid(doneValid),
    .doneReady(doneReady), .doneCid(doneCid), .doneStatus(doneStatus), .cplValid(cplValid),
    .cplReady(cplReady), .cplAddr(cplAddr), .cplData(cplData), .irq(irq));

  always #2 clk = ~clk;  // 250 MHz

  int nChecks = 0, nFails = 0;
  bit finished = 0, running = 0, randOn = 0;

  // bench models
  int hostTail = 0, sqTailM = 0, cqHeadM = 0, cqTailM = 0, expHead = 0, lastSlot = 0;
  int submitted = 0, fetched = 0, cmdsAcc = 0, posted = 0;
  bit phaseM = 1, errM = 0, cplPendM = 0;
  bit fetchAccLast = 0, doneAccLast = 0, cplAccLast = 0;
  logic [511:0] sqMem [QD];
  logic [511:0] cmdExpQ [$];
  logic [15:0]  engQ [$];
  logic [127:0] cplExpQ [$];

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nextP(input int p);
    return (p + 1) % QD;
  endfunction

  function automatic logic [127:0] cplEntry(input int head, input logic [15:0] cid,
                                            input bit ph, input logic [14:0] st);
    logic [127:0] v = '0;
    v[15:0]  = 16'(head);
    v[31:16] = cid;
    v[32]    = ph;
    v[47:33] = st;
    return v;
  endfunction

  // memory, engine and completion sink, plus per-cycle checks
  always @(negedge clk) begin
    if (running) begin
      bit fetchAcc, doneAcc, cmdAcc, cplAcc;
      // doorbell write that took effect at the last edge
      if (dbWrEn && dbWrQid == 16'(QID)) begin
        if (int'(dbWrData) < QD) begin
          if (dbWrSel == 1'b0) sqTailM = int'(dbWrData);
          else cqHeadM = int'(dbWrData);
        end else errM = 1;
      end
      check(irq == cplAccLast, "R7 irq", 512'(irq), 512'(cplAccLast));
      check(dbErr == errM, "R10 dbErr", 512'(dbErr), 512'(errM));
      check(doneReady == (!cplPendM && nextP(cqTailM) != cqHeadM), "R8 doneReady",
            512'(doneReady), 512'(!cplPendM && nextP(cqTailM) != cqHeadM));
      // new input values
      rdReqReady = randOn ? ($urandom % 3 != 0) : 1'b1;
      cmdReady   = randOn ? ($urandom % 3 != 0) : 1'b1;
      cplReady   = randOn ? ($urandom % 3 != 0) : 1'b1;
      rdRspValid = fetchAccLast;
      if (fetchAccLast) rdRspData = sqMem[lastSlot];
      if (doneAccLast) doneValid = 0;
      if (!doneValid && engQ.size() > 0 && ($urandom % 2 == 1)) begin
        doneValid  = 1;
        doneCid    = engQ.pop_front();
        doneStatus = 15'($urandom);
      end
      // handshakes at the coming edge
      fetchAcc = rdReqValid && rdReqReady;
      doneAcc  = doneValid && doneReady;
      cmdAcc   = cmdValid && cmdReady;
      cplAcc   = cplValid && cplReady;
      if (doneAcc) begin
        cplExpQ.push_back(cplEntry(cmdsAcc % QD, doneCid, phaseM, doneStatus));
        cplPendM = 1;
      end
      if (cplAcc) begin
        logic [127:0] e;
        e = cplExpQ.pop_front();
        check(cplAddr == CQB + 32'(cqTailM * 16), "R5 cplAddr", 512'(cplAddr), 512'(CQB + 32'(cqTailM * 16)));
        check(cplData[32] == e[32], "R6 phase", 512'(cplData[32]), 512'(e[32]));
        check(cplData == e, "R5 cplData", 512'(cplData), 512'(e));
        if (cqTailM == QD - 1) phaseM = ~phaseM;
        cqTailM = nextP(cqTailM);
        posted++;
        cplPendM = 0;
      end
      if (fetchAcc) begin
        check(rdReqAddr == SQB + 32'(expHead * 64), "R2 fetch addr", 512'(rdReqAddr), 512'(SQB + 32'(expHead * 64)));
        check(expHead != sqTailM, "R2 beyond doorbell", 512'(expHead), 512'(sqTailM));
        check(fetched == cmdsAcc, "R3 outstanding", 512'(fetched), 512'(cmdsAcc));
        lastSlot = expHead;
        expHead  = nextP(expHead);
        fetched++;
      end
      if (cmdAcc) begin
        logic [511:0] c;
        c = cmdExpQ.pop_front();
        check(cmdData == c, "R4 cmdData", cmdData, c);
        engQ.push_back(cmdData[15:0]);
        cmdsAcc++;
      end
      fetchAccLast = fetchAcc;
      doneAccLast  = doneAcc;
      cplAccLast   = cplAcc;
    end
  end

  task automatic dbWrite(input bit sel, input int qid, input int val);
    @(negedge clk); #1;
    dbWrEn = 1; dbWrSel = sel; dbWrQid = 16'(qid); dbWrData = 16'(val);
    @(negedge clk); #1;
    dbWrEn = 0;
  endtask

  task automatic putCmd();
    logic [511:0] e;
    for (int w = 0; w < 16; w++) e[w*32 +: 32] = $urandom;
    e[15:0] = 16'(submitted);
    sqMem[hostTail] = e;
    cmdExpQ.push_back(e);
    hostTail = nextP(hostTail);
    submitted++;
  endtask

  task automatic waitPosted(input int n);
    for (int i = 0; i < 2000 && posted < n; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!rdReqValid && !cmdValid && !cplValid, "R1 valids", 512'({rdReqValid, cmdValid, cplValid}), 512'(0));
    check(!irq && !dbErr, "R1 irq/err", 512'({irq, dbErr}), 512'(0));
    check(doneReady == 1, "R1 doneReady", 512'(doneReady), 512'(1));
    running = 1;
    repeat (3) @(negedge clk);
    check(fetched == 0, "R1 no fetch when empty", 512'(fetched), 512'(0));

    // R11: foreign queue id ignored
    dbWrite(0, QID + 1, 3);
    repeat (6) @(negedge clk);
    check(fetched == 0, "R11 foreign doorbell fetched", 512'(fetched), 512'(0));
    check(dbErr == 0, "R11 foreign doorbell error", 512'(dbErr), 512'(0));

    // R10: out-of-range values ignored, sticky error
    dbWrite(0, QID, QD);
    dbWrite(1, QID, QD + 3);
    repeat (6) @(negedge clk);
    check(fetched == 0, "R10 bad tail fetched", 512'(fetched), 512'(0));
    check(dbErr == 1, "R10 dbErr set", 512'(dbErr), 512'(1));
    check(doneReady == 1, "R10 cq head unchanged", 512'(doneReady), 512'(1));

    // R8/R9: fill the completion ring
    for (int i = 0; i < QD - 1; i++) putCmd();
    dbWrite(0, QID, hostTail);
    waitPosted(QD - 1);
    check(posted == QD - 1, "R5 posted before full", 512'(posted), 512'(QD - 1));
    putCmd();
    dbWrite(0, QID, hostTail);
    repeat (40) @(negedge clk);
    check(posted == QD - 1, "R8 stalled when full", 512'(posted), 512'(QD - 1));
    check(doneReady == 0 && doneValid == 1, "R8 done blocked", 512'({doneReady, doneValid}), 512'(2'b01));
    dbWrite(1, QID, cqTailM);
    waitPosted(QD);
    check(posted == QD, "R9 freed slot used", 512'(posted), 512'(QD));
    dbWrite(1, QID, cqTailM);

    // random traffic with back-pressure
    randOn = 1;
    for (int it = 0; it < 400; it++) begin
      if ($urandom % 2 == 1) begin
        int n = 1 + $urandom % 3;
        for (int k = 0; k < n && (submitted - cmdsAcc) < QD - 1; k++) putCmd();
        dbWrite(0, QID, hostTail);
      end
      if ($urandom % 2 == 1 && cqHeadM != cqTailM) dbWrite(1, QID, cqTailM);
      repeat ($urandom % 4) @(negedge clk);
    end
    for (int i = 0; i < 3000 && posted < submitted; i++) begin
      if (cqHeadM != cqTailM) dbWrite(1, QID, cqTailM);
      else @(negedge clk);
    end
    check(posted == submitted, "R4 all commands completed", 512'(posted), 512'(submitted));
    check(fetched == submitted, "R2 all commands fetched", 512'(fetched), 512'(submitted));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule